// File: doc/BRIEF.md
# DSI Link Clock Rate Calculator

This block works out the serial link clock, in kHz, that a DSI video stream needs for a given display timing. The caller presents the horizontal widths (active, front porch, sync, back porch), the vertical line counts for the same four regions, the refresh rate, a pixel format code, a video mode code, the lane count and an end-of-transmission packet enable. A one-cycle `start_i` pulse latches all of them. The block then counts the bytes of one line, including the fixed packet overheads, and scales that count up to a frame. It multiplies by the refresh rate and divides down to a per-lane bit rate.

The arithmetic runs over a few dozen cycles. `busy_o` is high while a calculation runs. `done_o` pulses for one cycle when `clk_khz_o` and `err_o` are valid. Both outputs then hold until the next calculation finishes. The two divisions share one restoring divider, so one result takes about 2*W+5 cycles.

Top module: `dsi_clk_calc`

## Requirements
- R1: Bits per pixel come from `fmt_i`. Codes 0 and 1 give 24, code 2 gives 18, code 3 gives 16, and every other code gives 24.
- R2: Each horizontal region costs ceil(pixels*bpp/8) bytes. A line is the sum of the four region byte counts plus a fixed overhead of 32 bytes.
- R3: When `mode_i` is 2 (burst) and `eot_en_i` is 1, 4 extra bytes are added to every line.
- R4: Frame bytes are line bytes times the sum of the four vertical counts. When `mode_i` is 0 or 1 (non-burst) and `eot_en_i` is 1, 4 bytes are added once per frame. Mode code 3 adds no end-of-transmission bytes.
- R5: With L lanes and a refresh rate of F, `clk_khz_o` is floor(floor(frame*F/L)*8/1000). The result is exact whenever frame*F*8 fits in W bits.
- R6: When `mode_i` is 2 and `eot_en_i` is 1, the result of R5 is doubled.
- R7: A lane count of 0 gives `err_o`=1 and `clk_khz_o`=0 with `done_o`. The next run with a non-zero lane count clears `err_o`.
- R8: Inputs are sampled only on the edge that accepts `start_i` while idle. Input changes and `start_i` pulses during `busy_o` have no effect on the result and produce no extra `done_o`.
- R9: `busy_o` rises on the cycle after an accepted start. `done_o` lasts exactly one cycle, and `busy_o` is low whenever `done_o` is high.
- R10: After reset, `busy_o`, `done_o`, `err_o` and `clk_khz_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calculation (accepted when idle) |
| h_active_i | input | H_W | Active pixels per line |
| h_front_i | input | H_W | Horizontal front porch pixels |
| h_sync_i | input | H_W | Horizontal sync pixels |
| h_back_i | input | H_W | Horizontal back porch pixels |
| v_active_i | input | V_W | Active lines |
| v_front_i | input | V_W | Vertical front porch lines |
| v_sync_i | input | V_W | Vertical sync lines |
| v_back_i | input | V_W | Vertical back porch lines |
| refresh_i | input | R_W | Frames per second |
| fmt_i | input | 3 | Pixel format code |
| mode_i | input | 2 | Video mode: 0/1 non-burst, 2 burst, 3 no EoT adjustment |
| lanes_i | input | L_W | Number of data lanes |
| eot_en_i | input | 1 | End-of-transmission packets enabled |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| err_o | output | 1 | Last result was rejected for a zero lane count |
| clk_khz_o | output | W | Link clock in kHz |

## Verification
The arithmetic stages feed each other, so a wrong intermediate value has only one place to show up: the `clk_khz_o` word delivered with the next `done_o`, about a hundred cycles after the start. An error in the format decode, the rounding or the overhead constant shows up only for some choices of format and pixel count. The bench therefore uses odd pixel counts, every format code and every mode code. A fault in the sequencing instead shows in the handshake: a missing or doubled `done_o`, a `busy_o` that never falls, or a result that moves between pulses. These can be seen on the cycle they occur.

// File: rtl/dsi_calc_pkg.sv
package dsi_calc_pkg;

  localparam logic [2:0] FMT_RGB888       = 3'd0;
  localparam logic [2:0] FMT_RGB666_LOOSE = 3'd1;
  localparam logic [2:0] FMT_RGB666       = 3'd2;
  localparam logic [2:0] FMT_RGB565       = 3'd3;

  localparam logic [1:0] MODE_NB_PULSE = 2'd0;
  localparam logic [1:0] MODE_NB_EVENT = 2'd1;
  localparam logic [1:0] MODE_BURST    = 2'd2;

  // sync start + sync end (4 each) + four packets of 6 bytes extra each
  localparam int unsigned LINE_OVERHEAD = 32;
  localparam int unsigned EOT_BYTES     = 4;
  localparam int unsigned KHZ_DIV       = 1000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LINE,
    ST_FRAME,
    ST_RATE,
    ST_LANE_GO,
    ST_LANE_DIV,
    ST_KHZ_DIV
  } calc_state_e;

  function automatic logic [4:0] bpp_of(input logic [2:0] fmt);
    case (fmt)
      FMT_RGB666: bpp_of = 5'd18;
      FMT_RGB565: bpp_of = 5'd16;
      default:    bpp_of = 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/dsi_line_bytes.sv
module dsi_line_bytes #(
  parameter int unsigned H_W    = 16,
  parameter int unsigned LINE_W = H_W + 5
) (
  input  logic [3:0][H_W-1:0] px_i,
  input  logic [2:0]          fmt_i,
  input  logic                add_eot_i,
  output logic [LINE_W-1:0]   line_o
);
  import dsi_calc_pkg::*;

  localparam int unsigned PROD_W = H_W + 5;

  logic [4:0]        bpp;
  logic [PROD_W-1:0] reg_bytes [4];

  assign bpp = bpp_of(fmt_i);

  for (genvar g = 0; g < 4; g++) begin : g_region
    logic [PROD_W-1:0] bits;
    assign bits         = PROD_W'(px_i[g]) * PROD_W'(bpp);
    assign reg_bytes[g] = (bits + PROD_W'(7)) >> 3;
  end

  always_comb begin
    line_o = LINE_W'(LINE_OVERHEAD);
    for (int i = 0; i < 4; i++) line_o = line_o + LINE_W'(reg_bytes[i]);
    if (add_eot_i) line_o = line_o + LINE_W'(EOT_BYTES);
  end

endmodule

// File: rtl/dsi_seq_div.sv
module dsi_seq_div #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, quo_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [W:0]       trial;
  logic             fits;
  logic [W-1:0]     rem_d, quo_d;

  // restoring step: shift in next dividend bit, subtract if it fits
  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    fits  = trial >= {1'b0, den_q};
    rem_d = fits ? (trial[W-1:0] - den_q) : trial[W-1:0];
    quo_d = {quo_q[W-2:0], fits};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !run_q) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        den_q <= divisor_i;
        cnt_q <= CNT_W'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_d;
        quo_q <= quo_d;
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;

endmodule

// File: rtl/dsi_clk_calc.sv
module dsi_clk_calc #(
  parameter int unsigned H_W = 16,
  parameter int unsigned V_W = 16,
  parameter int unsigned R_W = 8,
  parameter int unsigned L_W = 3,
  parameter int unsigned W   = 48
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [H_W-1:0] h_active_i,
  input  logic [H_W-1:0] h_front_i,
  input  logic [H_W-1:0] h_sync_i,
  input  logic [H_W-1:0] h_back_i,
  input  logic [V_W-1:0] v_active_i,
  input  logic [V_W-1:0] v_front_i,
  input  logic [V_W-1:0] v_sync_i,
  input  logic [V_W-1:0] v_back_i,
  input  logic [R_W-1:0] refresh_i,
  input  logic [2:0]     fmt_i,
  input  logic [1:0]     mode_i,
  input  logic [L_W-1:0] lanes_i,
  input  logic           eot_en_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic [W-1:0]   clk_khz_o
);
  import dsi_calc_pkg::*;

  localparam int unsigned LINE_W = H_W + 5;
  localparam int unsigned VT_W   = V_W + 2;

  calc_state_e        st_q;
  logic [3:0][H_W-1:0] h_q;
  logic [VT_W-1:0]    vtot_q;
  logic [R_W-1:0]     refresh_q;
  logic [2:0]         fmt_q;
  logic [1:0]         mode_q;
  logic [L_W-1:0]     lanes_q;
  logic               eot_q;
  logic [LINE_W-1:0]  line_q, line_w;
  logic [W-1:0]       frame_q, prod_q;
  logic               burst_eot, nb_eot;
  logic               div_start, div_done;
  logic [W-1:0]       div_dvd, div_den, div_quot;

  assign burst_eot = eot_q && (mode_q == MODE_BURST);
  assign nb_eot    = eot_q && ((mode_q == MODE_NB_PULSE) || (mode_q == MODE_NB_EVENT));

  dsi_line_bytes #(.H_W(H_W), .LINE_W(LINE_W)) u_line (
    .px_i      (h_q),
    .fmt_i     (fmt_q),
    .add_eot_i (burst_eot),
    .line_o    (line_w)
  );

  dsi_seq_div #(.W(W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (div_dvd),
    .divisor_i  (div_den),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  // one divider: first per-lane bytes, then bits to kHz
  always_comb begin
    div_start = 1'b0;
    div_dvd   = prod_q;
    div_den   = W'(lanes_q);
    if (st_q == ST_LANE_GO) begin
      div_start = 1'b1;
    end else if (st_q == ST_LANE_DIV && div_done) begin
      div_start = 1'b1;
      div_dvd   = div_quot << 3;
      div_den   = W'(KHZ_DIV);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      h_q       <= '0;
      vtot_q    <= '0;
      refresh_q <= '0;
      fmt_q     <= '0;
      mode_q    <= '0;
      lanes_q   <= '0;
      eot_q     <= 1'b0;
      line_q    <= '0;
      frame_q   <= '0;
      prod_q    <= '0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      clk_khz_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          h_q       <= {h_back_i, h_sync_i, h_front_i, h_active_i};
          vtot_q    <= VT_W'(v_active_i) + VT_W'(v_front_i)
                     + VT_W'(v_sync_i) + VT_W'(v_back_i);
          refresh_q <= refresh_i;
          fmt_q     <= fmt_i;
          mode_q    <= mode_i;
          lanes_q   <= lanes_i;
          eot_q     <= eot_en_i;
          st_q      <= ST_LINE;
        end
        ST_LINE: begin
          line_q <= line_w;
          st_q   <= ST_FRAME;
        end
        ST_FRAME: begin
          frame_q <= W'(line_q) * W'(vtot_q) + (nb_eot ? W'(EOT_BYTES) : W'(0));
          st_q    <= ST_RATE;
        end
        ST_RATE: begin
          prod_q <= frame_q * W'(refresh_q);
          if (lanes_q == '0) begin
            clk_khz_o <= '0;
            err_o     <= 1'b1;
            done_o    <= 1'b1;
            st_q      <= ST_IDLE;
          end else begin
            st_q <= ST_LANE_GO;
          end
        end
        ST_LANE_GO: st_q <= ST_LANE_DIV;
        ST_LANE_DIV: if (div_done) st_q <= ST_KHZ_DIV;
        ST_KHZ_DIV: if (div_done) begin
          clk_khz_o <= burst_eot ? (div_quot << 1) : div_quot;
          err_o     <= 1'b0;
          done_o    <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);

endmodule

// File: rtl/dsi_clk_calc_chk.sv
module dsi_clk_calc_chk #(
  parameter int unsigned W = 48
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         err_o,
  input logic [W-1:0] clk_khz_o
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R9

  AST_ERR_ZERO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (clk_khz_o == '0)); // R7

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(clk_khz_o) && $stable(err_o))); // R8

  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R8

endmodule

bind dsi_clk_calc dsi_clk_calc_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .clk_khz_o (clk_khz_o)
);

// File: tb/dsi_clk_calc_tb.sv
module dsi_clk_calc_tb;
  localparam int W = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] ha = '0, hf = '0, hs = '0, hb = '0;
  logic [15:0] va = '0, vf = '0, vs = '0, vb = '0;
  logic [7:0]  rf = '0;
  logic [2:0]  fmt = '0;
  logic [1:0]  mode = '0;
  logic [2:0]  lanes = '0;
  logic        eot = 1'b0;
  logic        busy, done, err;
  logic [W-1:0] khz;

  int checks = 0;
  int failures = 0;
  longint unsigned q_khz[$];
  bit              q_err[$];
  string           q_tag[$];
  logic            prev_done = 1'b0;

  always #4 clk = ~clk;

  dsi_clk_calc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .h_active_i(ha), .h_front_i(hf), .h_sync_i(hs), .h_back_i(hb),
    .v_active_i(va), .v_front_i(vf), .v_sync_i(vs), .v_back_i(vb),
    .refresh_i(rf), .fmt_i(fmt), .mode_i(mode), .lanes_i(lanes),
    .eot_en_i(eot), .busy_o(busy), .done_o(done), .err_o(err),
    .clk_khz_o(khz)
  );

  function automatic longint unsigned rbytes(int px, int bpp);
    return (longint'(px) * bpp + 7) / 8;
  endfunction

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run(string tag, int a_ha, int a_hf, int a_hs, int a_hb,
                     int a_va, int a_vf, int a_vs, int a_vb, int a_rf,
                     int a_fmt, int a_mode, int a_lanes, int a_eot, bit glitch);
    int bpp;
    bit be, ne;
    longint unsigned line, frame, res;
    bpp = (a_fmt == 2) ? 18 : (a_fmt == 3) ? 16 : 24;           // R1
    be = (a_mode == 2) && (a_eot != 0);
    ne = (a_mode == 0 || a_mode == 1) && (a_eot != 0);
    line = 32 + rbytes(a_ha, bpp) + rbytes(a_hf, bpp) + rbytes(a_hs, bpp)
         + rbytes(a_hb, bpp) + (be ? 4 : 0);                    // R2 R3
    frame = line * longint'(a_va + a_vf + a_vs + a_vb) + (ne ? 4 : 0); // R4
    if (a_lanes == 0) begin
      q_khz.push_back(0); q_err.push_back(1'b1);                // R7
    end else begin
      res = (frame * longint'(a_rf) / longint'(a_lanes)) * 8 / 1000; // R5
      if (be) res = res * 2;                                    // R6
      q_khz.push_back(res); q_err.push_back(1'b0);
    end
    q_tag.push_back(tag);
    @(negedge clk);
    ha = 16'(a_ha); hf = 16'(a_hf); hs = 16'(a_hs); hb = 16'(a_hb);
    va = 16'(a_va); vf = 16'(a_vf); vs = 16'(a_vs); vb = 16'(a_vb);
    rf = 8'(a_rf); fmt = 3'(a_fmt); mode = 2'(a_mode);
    lanes = 3'(a_lanes); eot = a_eot[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R9 busy after start"}, longint'(busy), 1);
    if (glitch) begin
      // R8: disturb inputs and restart while busy
      ha = 16'd3; va = 16'd1; rf = 8'd250; fmt = 3'd3; mode = 2'd2;
      lanes = 3'd0; eot = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({tag, " R8 still busy"}, longint'(busy), 1);
    end
    wait (q_khz.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done) check("R9 done width", 1, 0);
      if (done) begin
        check("R9 busy low at done", longint'(busy), 0);
        if (q_khz.size() == 0) begin
          check("R8 unexpected done", 1, 0);
        end else begin
          check({q_tag[0], " khz"}, longint'(khz), q_khz[0]);
          check({q_tag[0], " err"}, longint'(err), longint'(q_err[0]));
          void'(q_khz.pop_front());
          void'(q_err.pop_front());
          void'(q_tag.pop_front());
        end
      end
      prev_done <= done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 busy", longint'(busy), 0);
    check("R10 done", longint'(done), 0);
    check("R10 err", longint'(err), 0);
    check("R10 khz", longint'(khz), 0);

    run("R5 R4 nb-pulse eot 4 lanes", 1920, 88, 44, 148, 1080, 4, 5, 36, 60, 0, 0, 4, 1, 0);
    run("R1 loose666", 1920, 88, 44, 148, 1080, 4, 5, 36, 60, 1, 0, 4, 1, 0);
    run("R1 R2 packed666 odd px", 801, 13, 7, 9, 600, 3, 2, 21, 60, 2, 1, 3, 0, 0);
    run("R1 rgb565", 1280, 110, 40, 220, 720, 5, 5, 20, 60, 3, 0, 2, 0, 0);
    run("R1 unknown fmt", 1280, 110, 40, 220, 720, 5, 5, 20, 50, 6, 1, 2, 1, 0);
    run("R3 R6 burst eot", 1080, 26, 4, 30, 1920, 8, 2, 14, 60, 0, 2, 4, 1, 0);
    run("R3 burst no eot", 1080, 26, 4, 30, 1920, 8, 2, 14, 60, 0, 2, 4, 0, 0);
    run("R4 mode3 eot", 1080, 26, 4, 30, 1920, 8, 2, 14, 60, 2, 3, 4, 1, 0);
    run("R7 zero lanes", 800, 40, 20, 40, 480, 10, 2, 20, 60, 0, 0, 0, 1, 0);
    run("R7 err cleared", 800, 40, 20, 40, 480, 10, 2, 20, 60, 0, 0, 1, 1, 0);
    run("R8 busy ignore", 1024, 24, 136, 160, 768, 3, 6, 29, 60, 3, 1, 3, 1, 1);
    run("R5 R6 wide", 65535, 65535, 65535, 65535, 65535, 65535, 65535, 65535, 60, 0, 2, 1, 1, 0);
    run("R2 tiny", 1, 1, 1, 1, 1, 1, 1, 1, 1, 2, 3, 1, 0, 0);

    repeat (5) @(negedge clk);
    check("R8 no stray done", longint'(q_khz.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule